// File: doc/BRIEF.md
# Graphic LCD Column Driver Host Interface

This block is the processor-facing side of a 64-column graphic LCD column driver. It has an 8-bit byte-wide bus with separate data-in, data-out and output-enable ports. The bus is qualified by an enable strobe, a read/write line and a data/instruction line, and it is gated by three chip selects. An active-low reset pin completes the interface. Bus instructions turn the display on or off, choose the start line used for scrolling, and set the page and column of the next memory access. Data accesses write or read the internal frame memory of 8 pages by 64 columns of bytes. The column advances by one after each access.

All strobes and bus data are resynchronised to the system clock by two flops. Falling edges of the enable strobe are detected in that clock domain. A control state machine then executes the captured access and holds a busy flag for a short window. Reads are pipelined through an output register. The value shown on the bus is the one fetched by the previous read, so software discards one read after each address change. The display-enable flag and the start-line value are exported for the scanning logic.

The control state machine has four states. ST_RESET is held while the synchronised reset is low. ST_IDLE waits for an access. ST_EXEC performs the captured access. ST_BUSY counts out the rest of the busy window. The transitions are as follows:
- T_RST: any state moves to ST_RESET while reset is low.
- T_REL: ST_RESET moves to ST_IDLE once reset is released.
- T_ACCEPT: ST_IDLE moves to ST_EXEC on a selected strobe fall that is not a status read.
- T_DONE: ST_EXEC always moves to ST_BUSY.
- T_READY: ST_BUSY moves to ST_IDLE when its counter reaches zero.

Top module: `glcd_host_if`

## Requirements
- R1: The chip is selected only when cs1_n=0, cs2_n=0 and cs3=1. A strobe fall while the chip is deselected writes no memory, runs no instruction and leaves the column counter unchanged, and dout_oe stays 0 while the chip is deselected.
- R2: dout_oe is 1 only while e, rw and the selection (as seen two clocks earlier) are all active. A write strobe never drives the bus.
- R3: With di=0 and rw=0, the code 0011111D sets disp_on to D (1 means on), and the code 11AAAAAA loads start_line with AAAAAA.
- R4: With di=0 and rw=0, the code 10111PPP selects page PPP and the code 01CCCCCC selects column CCCCCC. With di=1 and rw=0, the din byte is stored at address {page, column}.
- R5: Every data write or data read advances the column by one, wrapping from 63 to 0. The page never changes by itself.
- R6: A status read (di=0, rw=1) returns a byte with bit 7 = busy, bit 5 = display off, bit 4 = reset active, and all other bits 0. Examples: 0x30 during reset, 0x20 when idle with the display off, 0x00 when idle with the display on.
- R7: A data read (di=1, rw=1) drives the output register while e is high. At the strobe fall it loads the byte at the current address into that register. The first read after an address change therefore returns the previously loaded byte, and instructions leave the register unchanged.
- R8: After each accepted instruction or data access, the busy bit reads 1 for exactly BUSY_CYCLES+1 clocks (3 with defaults). A strobe fall that arrives while busy is ignored.
- R9: While reset is low, disp_on is 0, start_line is 0, status reads still work and return 0x30, and instructions are ignored.
- R10: Each of the 8 pages holds its own 64 bytes. Writing one page leaves the same column in other pages unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous, resynchronised inside |
| e | input | 1 | Enable strobe; writes and reads complete at its fall |
| cs1_n | input | 1 | Chip select, active low |
| cs2_n | input | 1 | Chip select, active low |
| cs3 | input | 1 | Chip select, active high |
| rw | input | 1 | 1 = read, 0 = write |
| di | input | 1 | 1 = display data, 0 = instruction/status |
| din | input | DATA_W | Bus data driven by the processor |
| dout | output | DATA_W | Bus data driven by the block |
| dout_oe | output | 1 | Output enable for dout |
| disp_on | output | 1 | Display enable flag |
| start_line | output | COL_W | Display start line |

## Verification
The hardest situation to reach from the ports is a strobe fall that arrives inside the busy window. The two-flop resynchronisation and the edge detector delay every access, so a normally paced bus never overlaps with busy. The stimulus drops the strobe for one write, raises it again one clock later with different data, and drops it two clocks after that. This places the second fall in the last busy cycle. A following write and a readback then show that only one byte landed and that the column advanced once. A related test raises the strobe for a status read one clock after a write's fall and counts the busy cycles it sees.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

    typedef enum logic [1:0] {
        ST_RESET,
        ST_IDLE,
        ST_EXEC,
        ST_BUSY
    } ctrl_state_e;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_DISP,
        OP_START,
        OP_PAGE,
        OP_COL
    } instr_op_e;

    localparam int STAT_BUSY_BIT = 7;
    localparam int STAT_OFF_BIT  = 5;
    localparam int STAT_RST_BIT  = 4;

endpackage

// File: rtl/glcd_sync.sv
module glcd_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            chain <= {chain[STAGES-2:0], async_in[i]};
        end
        assign sync_out[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/glcd_cmd_decode.sv
module glcd_cmd_decode
    import glcd_pkg::*;
#(
    parameter int PAGE_W = 3,
    parameter int COL_W  = 6
) (
    input  logic [7:0]        code,
    output instr_op_e         op,
    output logic              disp_arg,
    output logic [COL_W-1:0]  line_arg,
    output logic [PAGE_W-1:0] page_arg,
    output logic [COL_W-1:0]  col_arg
);

    always_comb begin
        unique casez (code)
            8'b0011111?: op = OP_DISP;
            8'b11??????: op = OP_START;
            8'b10111???: op = OP_PAGE;
            8'b01??????: op = OP_COL;
            default:     op = OP_NOP;
        endcase
    end

    assign disp_arg = code[0];
    assign line_arg = code[COL_W-1:0];
    assign page_arg = code[PAGE_W-1:0];
    assign col_arg  = code[COL_W-1:0];

endmodule

// File: rtl/glcd_frame_ram.sv
module glcd_frame_ram #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/glcd_host_if.sv
module glcd_host_if
    import glcd_pkg::*;
#(
    parameter int PAGE_W      = 3,
    parameter int COL_W       = 6,
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e,
    input  logic              cs1_n,
    input  logic              cs2_n,
    input  logic              cs3,
    input  logic              rw,
    input  logic              di,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              disp_on,
    output logic [COL_W-1:0]  start_line
);

    localparam int ADDR_W = PAGE_W + COL_W;
    localparam int SYNC_W = DATA_W + 7;
    localparam int CNT_W  = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);

    // resynchronised bus
    logic [SYNC_W-1:0] sync_vec;
    logic              rst_s, e_s, cs1_s, cs2_s, cs3_s, rw_s, di_s;
    logic [DATA_W-1:0] din_s;
    logic              e_prev, e_fall, sel_s, status_rd, accept;

    // control
    ctrl_state_e       state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic              busy;

    // captured access
    logic              cmd_rw, cmd_di;
    logic [DATA_W-1:0] cmd_data;

    // decoded instruction
    instr_op_e         op;
    logic              disp_arg;
    logic [COL_W-1:0]  line_arg, col_arg;
    logic [PAGE_W-1:0] page_arg;

    // architectural state
    logic              disp_on_q;
    logic [COL_W-1:0]  start_q;
    logic [PAGE_W-1:0] page_q;
    logic [COL_W-1:0]  col_q;
    logic [DATA_W-1:0] outreg_q;
    logic [DATA_W-1:0] ram_rd;
    logic              ram_we;
    logic [DATA_W-1:0] status;

    glcd_sync #(.WIDTH(SYNC_W), .STAGES(2)) u_sync (
        .clk      (clk),
        .async_in ({rst_n, e, cs1_n, cs2_n, cs3, rw, di, din}),
        .sync_out (sync_vec)
    );

    assign {rst_s, e_s, cs1_s, cs2_s, cs3_s, rw_s, di_s, din_s} = sync_vec;

    always_ff @(posedge clk) begin
        e_prev <= e_s;
    end

    assign e_fall    = e_prev && !e_s;
    assign sel_s     = !cs1_s && !cs2_s && cs3_s;
    assign status_rd = rw_s && !di_s;
    assign accept    = (state == ST_IDLE) && e_fall && sel_s && !status_rd;

    // ---------------- state register ----------------
    always_comb begin
        state_nx = state;
        if (!rst_s) begin
            state_nx = ST_RESET;                        // T_RST
        end else begin
            unique case (state)
                ST_RESET: state_nx = ST_IDLE;           // T_REL
                ST_IDLE:  if (accept) state_nx = ST_EXEC; // T_ACCEPT
                ST_EXEC:  state_nx = ST_BUSY;           // T_DONE
                ST_BUSY:  if (cnt == '0) state_nx = ST_IDLE; // T_READY
                default:  state_nx = ST_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state <= state_nx;
    end

    // ---------------- access capture ----------------
    always_ff @(posedge clk) begin
        if (!rst_s) begin
            cmd_rw   <= 1'b0;
            cmd_di   <= 1'b0;
            cmd_data <= '0;
        end else if (accept) begin
            cmd_rw   <= rw_s;
            cmd_di   <= di_s;
            cmd_data <= din_s;
        end
    end

    glcd_cmd_decode #(.PAGE_W(PAGE_W), .COL_W(COL_W)) u_dec (
        .code     (cmd_data[7:0]),
        .op       (op),
        .disp_arg (disp_arg),
        .line_arg (line_arg),
        .page_arg (page_arg),
        .col_arg  (col_arg)
    );

    // ---------------- state actions ----------------
    always_ff @(posedge clk) begin
        if (!rst_s) begin
            disp_on_q <= 1'b0;
            start_q   <= '0;
            page_q    <= '0;
            col_q     <= '0;
            outreg_q  <= '0;
            cnt       <= '0;
        end else begin
            unique case (state)
                ST_EXEC: begin
                    cnt <= CNT_W'(BUSY_CYCLES - 1);
                    if (cmd_di) begin
                        col_q <= col_q + 1'b1;
                        if (cmd_rw) outreg_q <= ram_rd;
                    end else begin
                        unique case (op)
                            OP_DISP:  disp_on_q <= disp_arg;
                            OP_START: start_q   <= line_arg;
                            OP_PAGE:  page_q    <= page_arg;
                            OP_COL:   col_q     <= col_arg;
                            default:  ;
                        endcase
                    end
                end
                ST_BUSY: if (cnt != '0) cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    assign ram_we = (state == ST_EXEC) && cmd_di && !cmd_rw;

    glcd_frame_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk     (clk),
        .wr_en   (ram_we),
        .wr_addr ({page_q, col_q}),
        .wr_data (cmd_data),
        .rd_addr ({page_q, col_q}),
        .rd_data (ram_rd)
    );

    // ---------------- outputs ----------------
    always_comb begin
        busy                  = (state == ST_EXEC) || (state == ST_BUSY);
        status                = '0;
        status[STAT_BUSY_BIT] = busy;
        status[STAT_OFF_BIT]  = !disp_on_q;
        status[STAT_RST_BIT]  = !rst_s;
        dout                  = di_s ? outreg_q : status;
        dout_oe               = e_s && rw_s && sel_s;
        disp_on               = disp_on_q;
        start_line            = start_q;
    end

endmodule

// File: rtl/glcd_host_if_chk.sv
module glcd_host_if_chk
    import glcd_pkg::*;
#(
    parameter int COL_W       = 6,
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 2
) (
    input logic              clk,
    input logic              rst_s,
    input logic              e,
    input logic              cs1_n,
    input logic              cs2_n,
    input logic              cs3,
    input logic              rw,
    input ctrl_state_e       state,
    input logic              e_fall,
    input logic              sel_s,
    input logic              di_s,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe,
    input logic [COL_W-1:0]  col_q,
    input logic [DATA_W-1:0] outreg_q,
    input logic              cmd_di,
    input logic              cmd_rw,
    input logic              busy,
    input logic              disp_on,
    input logic [COL_W-1:0]  start_line
);

    logic [7:0] busy_run;
    logic       rst_seen;

    always_ff @(posedge clk) begin
        if (!rst_s)                 busy_run <= '0;
        else if (!busy)             busy_run <= '0;
        else if (busy_run != 8'hFF) busy_run <= busy_run + 1'b1;
    end

    always_ff @(posedge clk) begin
        rst_seen <= !rst_s;
    end

    p_oe_gate_r2: assert property (@(posedge clk) disable iff (!rst_s)
        dout_oe |-> ($past(e, 2) && $past(rw, 2) && !$past(cs1_n, 2)
                     && !$past(cs2_n, 2) && $past(cs3, 2)))
        else $error("dout_oe without qualified read");

    p_desel_idle_r1: assert property (@(posedge clk) disable iff (!rst_s)
        (state == ST_IDLE && e_fall && !sel_s) |=> (state == ST_IDLE))
        else $error("deselected strobe started an access");

    p_status_pad_r6: assert property (@(posedge clk) disable iff (!rst_s)
        (dout_oe && !di_s) |-> (dout[6] == 1'b0 && dout[3:0] == 4'h0))
        else $error("status byte padding not zero");

    p_col_step_r5: assert property (@(posedge clk) disable iff (!rst_s)
        (state == ST_EXEC && cmd_di) |=> (col_q == $past(col_q) + 1'b1))
        else $error("column did not advance");

    p_outreg_keep_r7: assert property (@(posedge clk) disable iff (!rst_s)
        (state != ST_EXEC || !(cmd_di && cmd_rw)) |=> $stable(outreg_q))
        else $error("output register changed without a data read");

    p_exec_to_busy_r8: assert property (@(posedge clk) disable iff (!rst_s)
        (state == ST_EXEC) |=> (state == ST_BUSY))
        else $error("execute not followed by busy");

    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_s)
        busy_run <= 8'(BUSY_CYCLES + 1))
        else $error("busy window too long");

    always @(posedge clk) begin
        if (rst_seen) begin
            p_reset_clears_r9: assert (!disp_on && start_line == '0)
                else $error("reset did not clear display state");
        end
    end

endmodule

bind glcd_host_if glcd_host_if_chk #(
    .COL_W(COL_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_s      (rst_s),
    .e          (e),
    .cs1_n      (cs1_n),
    .cs2_n      (cs2_n),
    .cs3        (cs3),
    .rw         (rw),
    .state      (state),
    .e_fall     (e_fall),
    .sel_s      (sel_s),
    .di_s       (di_s),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .col_q      (col_q),
    .outreg_q   (outreg_q),
    .cmd_di     (cmd_di),
    .cmd_rw     (cmd_rw),
    .busy       (busy),
    .disp_on    (disp_on),
    .start_line (start_line)
);

// File: tb/glcd_host_if_test.sv
module glcd_host_if_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       e = 1'b0, cs1_n = 1'b1, cs2_n = 1'b1, cs3 = 1'b0;
    logic       rw = 1'b0, di = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_oe, disp_on;
    logic [5:0] start_line;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    glcd_host_if uut (
        .clk(clk), .rst_n(rst_n), .e(e), .cs1_n(cs1_n), .cs2_n(cs2_n),
        .cs3(cs3), .rw(rw), .di(di), .din(din), .dout(dout),
        .dout_oe(dout_oe), .disp_on(disp_on), .start_line(start_line)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic select_chip();
        cs1_n = 1'b0; cs2_n = 1'b0; cs3 = 1'b1;
    endtask

    task automatic bus_wr(input logic d, input logic [7:0] v);
        rw = 1'b0; di = d; din = v;
        repeat (2) @(negedge clk);
        e = 1'b1;
        repeat (4) @(negedge clk);
        e = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_rd(input logic d, output logic [7:0] v, output logic oe);
        rw = 1'b1; di = d;
        repeat (2) @(negedge clk);
        e = 1'b1;
        repeat (4) @(negedge clk);
        v = dout; oe = dout_oe;
        e = 1'b0;
        repeat (10) @(negedge clk);
        rw = 1'b0;
    endtask

    task automatic go_to(input logic [2:0] pg, input logic [5:0] cl);
        bus_wr(1'b0, {5'b10111, pg});
        bus_wr(1'b0, {2'b01, cl});
    endtask

    task automatic rd_data(output logic [7:0] v);
        logic oe;
        bus_rd(1'b1, v, oe);
    endtask

    task automatic rd_status(output logic [7:0] v);
        logic oe;
        bus_rd(1'b0, v, oe);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        select_chip();
        repeat (4) @(negedge clk);
        check("R9 disp_on in reset", disp_on, 0);
        check("R9 start_line in reset", start_line, 0);
        rd_status(v);
        check("R6/R9 status in reset", v, 8'h30);
        bus_wr(1'b0, 8'h3F);
        check("R9 instruction ignored in reset", disp_on, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        rd_status(v);
        check("R6 status after reset", v, 8'h20);
    endtask

    task automatic t_display();
        logic [7:0] v;
        bus_wr(1'b0, 8'h3F);
        check("R3 display on", disp_on, 1);
        rd_status(v);
        check("R6 status display on", v, 8'h00);
        bus_wr(1'b0, 8'hC0 | 8'd37);
        check("R3 start line 37", start_line, 37);
        bus_wr(1'b0, 8'hFF);
        check("R3 start line 63", start_line, 63);
        bus_wr(1'b0, 8'h3E);
        check("R3 display off", disp_on, 0);
        rd_status(v);
        check("R6 status display off", v, 8'h20);
        bus_wr(1'b0, 8'h3F);
        check("R3 display on again", disp_on, 1);
    endtask

    task automatic t_oe();
        logic [7:0] v;
        logic oe;
        rw = 1'b0; di = 1'b0; din = 8'h00;
        repeat (2) @(negedge clk);
        e = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 no drive on write", dout_oe, 0);
        e = 1'b0;
        repeat (10) @(negedge clk);
        bus_rd(1'b0, v, oe);
        check("R2 drive on selected read", oe, 1);
    endtask

    task automatic t_select();
        logic [7:0] v;
        logic oe;
        go_to(3'd0, 6'd0);
        bus_wr(1'b1, 8'h12);
        bus_wr(1'b1, 8'h34);
        bus_wr(1'b1, 8'h56);
        cs1_n = 1'b1;
        bus_wr(1'b1, 8'hEE);
        bus_rd(1'b0, v, oe);
        check("R1 no drive when deselected", oe, 0);
        cs1_n = 1'b0; cs2_n = 1'b1;
        bus_wr(1'b0, 8'h3E);
        check("R1 deselected instruction ignored", disp_on, 1);
        cs2_n = 1'b0; cs3 = 1'b0;
        bus_wr(1'b1, 8'hEE);
        select_chip();
        bus_wr(1'b1, 8'h78);
        bus_wr(1'b1, 8'h9A);
        go_to(3'd0, 6'd0);
        rd_data(v);
        rd_data(v);
        check("R4 readback col0", v, 8'h12);
        rd_data(v);
        check("R4 readback col1", v, 8'h34);
        rd_data(v);
        check("R4 readback col2", v, 8'h56);
        rd_data(v);
        check("R1 deselected writes skipped", v, 8'h78);
    endtask

    task automatic t_pipeline();
        logic [7:0] v;
        go_to(3'd2, 6'd5);
        bus_wr(1'b1, 8'hA5);
        bus_wr(1'b1, 8'h3C);
        go_to(3'd2, 6'd5);
        rd_data(v);
        check("R7 stale first read", v, 8'h9A);
        rd_data(v);
        check("R7 second read", v, 8'hA5);
        rd_data(v);
        check("R7 third read", v, 8'h3C);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        go_to(3'd2, 6'd0);
        bus_wr(1'b1, 8'h44);
        go_to(3'd1, 6'd63);
        bus_wr(1'b1, 8'h11);
        bus_wr(1'b1, 8'h22);
        bus_wr(1'b1, 8'h33);
        go_to(3'd1, 6'd63);
        rd_data(v);
        rd_data(v);
        check("R5 col63", v, 8'h11);
        rd_data(v);
        check("R5 wrap to col0", v, 8'h22);
        rd_data(v);
        check("R5 col1 after wrap", v, 8'h33);
        go_to(3'd2, 6'd0);
        rd_data(v);
        rd_data(v);
        check("R5 page unchanged by wrap", v, 8'h44);
    endtask

    task automatic t_pages();
        logic [7:0] v;
        go_to(3'd0, 6'd20); bus_wr(1'b1, 8'h55);
        go_to(3'd7, 6'd20); bus_wr(1'b1, 8'hAA);
        go_to(3'd3, 6'd20); bus_wr(1'b1, 8'hC3);
        go_to(3'd0, 6'd20); rd_data(v); rd_data(v);
        check("R10 page0", v, 8'h55);
        go_to(3'd7, 6'd20); rd_data(v); rd_data(v);
        check("R10 page7", v, 8'hAA);
        go_to(3'd3, 6'd20); rd_data(v); rd_data(v);
        check("R10 page3", v, 8'hC3);
    endtask

    task automatic t_busy_window();
        logic [7:0] v;
        int count = 0;
        rw = 1'b0; di = 1'b0; din = 8'h40;
        repeat (2) @(negedge clk);
        e = 1'b1;
        repeat (4) @(negedge clk);
        e = 1'b0;
        @(negedge clk);
        rw = 1'b1; di = 1'b0; e = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (dout_oe && dout[7]) count++;
        end
        e = 1'b0;
        repeat (10) @(negedge clk);
        rw = 1'b0;
        check("R8 busy cycle count", count, 3);
        rd_status(v);
        check("R8 busy cleared", v, 8'h00);
    endtask

    task automatic t_overlap();
        logic [7:0] v;
        go_to(3'd4, 6'd0);
        bus_wr(1'b1, 8'hD1);
        bus_wr(1'b1, 8'hD2);
        go_to(3'd4, 6'd0);
        rw = 1'b0; di = 1'b1; din = 8'hF0;
        repeat (2) @(negedge clk);
        e = 1'b1;
        repeat (4) @(negedge clk);
        e = 1'b0;
        @(negedge clk);
        din = 8'h0F; e = 1'b1;
        repeat (2) @(negedge clk);
        e = 1'b0;
        repeat (10) @(negedge clk);
        bus_wr(1'b1, 8'h77);
        go_to(3'd4, 6'd0);
        rd_data(v);
        rd_data(v);
        check("R8 first write landed", v, 8'hF0);
        rd_data(v);
        check("R8 write during busy ignored", v, 8'h77);
    endtask

    task automatic t_reset_again();
        logic [7:0] v;
        bus_wr(1'b0, 8'hC5);
        check("R3 start line before reset", start_line, 5);
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 disp_on cleared", disp_on, 0);
        check("R9 start_line cleared", start_line, 0);
        rd_status(v);
        check("R9 status during reset", v, 8'h30);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        rd_status(v);
        check("R9 status after release", v, 8'h20);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        t_reset();
        t_display();
        t_oe();
        t_select();
        t_pipeline();
        t_wrap();
        t_pages();
        t_busy_window();
        t_overlap();
        t_reset_again();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule